// File: doc/BRIEF.md
# Flow-through synchronous burst SRAM

This block is a synthesizable behavioural model of a synchronous cache SRAM with a flow-through read path. A word is 18 bits wide and is split into two 9-bit lanes. Each lane holds 8 data bits and 1 parity bit in its top position. The depth is `2**ADDR_W` words. The full part uses a 16-bit address, and the default is smaller so that simulation stays fast. Address, chip enables, strobes, advance, write controls and write data are all sampled on the rising clock edge. Read data comes combinationally from the registered address, so it is valid within the same cycle. The output enable and the sleep input act on the bus at once, with no clock edge.

Two address strobes can open an access. The processor strobe always opens a read. The controller strobe opens either a read or a write. After that, cycles with no strobe continue the access. When advance is low in such a cycle, the two low address bits step through a four-word block. The step is linear or interleaved, as the mode input selects.

The access state machine has three states:
- `S_IDLE`: no access open, bus not driven.
- `S_READ`: a read is in progress.
- `S_WRITE`: a write is in progress, bus not driven.

It has these transitions:
- T_SLEEP: any state goes to `S_IDLE` while sleep is high.
- T_DESEL: a strobe with the device not selected goes to `S_IDLE`.
- T_PROC_READ: the processor strobe goes to `S_READ`.
- T_CTRL_READ / T_CTRL_WRITE: the controller strobe goes to `S_READ` or `S_WRITE`.
- T_BURST_READ / T_BURST_WRITE: a continue cycle from `S_READ` or `S_WRITE` goes to `S_READ` or `S_WRITE`, chosen by the write controls.
- T_HOLD_IDLE: a continue cycle in `S_IDLE` stays there.

The data bus is split into `dq_i`, `dq_o` and a drive enable `dq_oe`, for a pad that is shared between input and output.

Top module: `fts_sram`

## Requirements
- R1: After reset the state is `S_IDLE` and `dq_oe` is 0.
- R2: An access opens on an edge in either of two cases: `strobe_proc_n`=0 together with `ce_first_n`=0, or `strobe_ctrl_n`=0. The processor strobe is ignored while `ce_first_n`=1. The device is selected only when `ce_first_n`=0, `ce_second`=1 and `ce_third_n`=0. An opening edge with the device not selected writes nothing, leaves `dq_oe`=0, and later continue cycles do nothing.
- R3: An access opened by the processor strobe is a read, and the write controls on that edge are ignored. If both strobes open on the same edge, the processor strobe wins.
- R4: Lane 0 is `dq[8:0]` and lane 1 is `dq[17:9]`; bit 8 of each lane is parity. `all_wr_n`=0 writes both lanes. Otherwise lane i is written only when `byte_wr_n`=0 and `lane_wr_n[i]`=0. With no lane qualified, the cycle is a read.
- R5: Read data for the address captured at an edge is on `dq_o`, with `dq_oe`=1, before the next edge.
- R6: With `interleave`=0, the n-th word of a burst has low address bits (base+n) mod 4. The upper bits stay fixed.
- R7: With `interleave`=1, the n-th word of a burst has low address bits base XOR n.
- R8: In a continue cycle, `advance_n`=0 steps the burst and `advance_n`=1 keeps the address. The cycle reads, or writes if the write controls ask for it, at that address.
- R9: `oe_n`=1 forces `dq_oe`=0 at once, with no clock edge. A write cycle never drives the bus.
- R10: `sleep`=1 forces `dq_oe`=0 at once. On edges while sleep is high, strobes, advance and writes are ignored and the array keeps its contents. After sleep falls, the bus stays undriven until a new access opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | ADDR_W | Word address |
| ce_first_n | input | 1 | Active-low enable that also qualifies the processor strobe |
| ce_second | input | 1 | Active-high depth-expansion enable |
| ce_third_n | input | 1 | Active-low depth-expansion enable |
| strobe_proc_n | input | 1 | Processor address strobe, active low |
| strobe_ctrl_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| byte_wr_n | input | 1 | Qualifier for the per-lane enables, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| interleave | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| dq_i | input | LANES*LANE_W | Write data from the pad |
| dq_o | output | LANES*LANE_W | Read data to the pad |
| dq_oe | output | 1 | Pad drive enable |

## Verification
A wrong access state shows at the ports within one cycle. The bus is driven during a write or after a deselect, or it stays silent during a read. A wrong burst counter shows as data from the wrong word on the very next read of a burst. In linear and interleaved mode, the bench reads every word of a four-word block, so that each permutation step can be seen. Errors in lane qualification, in write suppression during sleep, and in processor-strobe write masking show as changed data on the next read of the affected word.

// File: rtl/fts_sram_pkg.sv
`timescale 1ns/1ps
package fts_sram_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_READ  = 2'd1,
        S_WRITE = 2'd2
    } acc_state_e;

    // Low two address bits of the n-th word of a four-word burst.
    function automatic logic [1:0] burst_low(input logic [1:0] base,
                                             input logic [1:0] step_cnt,
                                             input logic       interleave);
        logic [1:0] res;
        if (interleave) res = base ^ step_cnt;
        else            res = base + step_cnt;
        return res;
    endfunction

endpackage

// File: rtl/fts_burst_ctr.sv
`timescale 1ns/1ps
module fts_burst_ctr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] access_addr,
    output logic [ADDR_W-1:0] cur_addr
);
    import fts_sram_pkg::*;

    localparam int HI_W = ADDR_W - 2;

    logic [ADDR_W-1:0] base_q, base_d;
    logic [1:0]        cnt_q, cnt_d;

    always_comb begin
        base_d = base_q;
        cnt_d  = cnt_q;
        if (load) begin
            base_d = start_addr;
            cnt_d  = 2'd0;
        end else if (step) begin
            cnt_d = cnt_q + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            base_q <= base_d;
            cnt_q  <= cnt_d;
        end
    end

    // Address used by a write on the current edge.
    assign access_addr = {base_d[ADDR_W-1 -: HI_W], burst_low(base_d[1:0], cnt_d, interleave)};
    // Address of the access opened by the last edge (flow-through read).
    assign cur_addr    = {base_q[ADDR_W-1 -: HI_W], burst_low(base_q[1:0], cnt_q, interleave)};

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> ($stable(cnt_q) && $stable(base_q)))
        else $error("burst position moved without load or step");

    assert_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])))
        else $error("burst left its four-word block");

    assert_load_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cur_addr == $past(start_addr)))
        else $error("first burst word differs from the start address");

endmodule

// File: rtl/fts_access_fsm.sv
`timescale 1ns/1ps
module fts_access_fsm (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sleep,
    input  logic                      start_proc,
    input  logic                      start_ctrl,
    input  logic                      selected,
    input  logic                      wr_req,
    input  logic                      oe_n,
    output fts_sram_pkg::acc_state_e  state,
    output logic                      bus_drive,
    output logic                      write_now
);
    import fts_sram_pkg::*;

    acc_state_e next_state;

    // Transition logic
    always_comb begin
        next_state = state;
        if (sleep) begin
            next_state = S_IDLE;                             // T_SLEEP
        end else if (start_proc || start_ctrl) begin
            if (!selected)       next_state = S_IDLE;        // T_DESEL
            else if (start_proc) next_state = S_READ;        // T_PROC_READ
            else if (wr_req)     next_state = S_WRITE;       // T_CTRL_WRITE
            else                 next_state = S_READ;        // T_CTRL_READ
        end else begin
            unique case (state)
                S_IDLE:          next_state = S_IDLE;        // T_HOLD_IDLE
                S_READ, S_WRITE: next_state = wr_req ? S_WRITE : S_READ; // T_BURST_*
                default:         next_state = S_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= next_state;
    end

    // Outputs
    always_comb begin
        bus_drive = 1'b0;
        unique case (state)
            S_READ:          bus_drive = !oe_n && !sleep;
            S_IDLE, S_WRITE: bus_drive = 1'b0;
            default:         bus_drive = 1'b0;
        endcase
        write_now = (next_state == S_WRITE);
    end

    assert_sleep_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (state == S_IDLE))
        else $error("access state not idle after a sleeping edge");

    assert_desel_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((start_proc || start_ctrl) && !selected && !sleep) |=> (state == S_IDLE))
        else $error("deselected strobe opened an access");

    assert_proc_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_proc && selected && !sleep) |=> (state == S_READ))
        else $error("processor strobe did not open a read");

endmodule

// File: rtl/fts_lane_array.sv
`timescale 1ns/1ps
module fts_lane_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [LANES-1:0]          wr_en,
    input  logic [LANES*LANE_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [LANES*LANE_W-1:0]   rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
    end

endmodule

// File: rtl/fts_sram.sv
`timescale 1ns/1ps
module fts_sram #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    ce_first_n,
    input  logic                    ce_second,
    input  logic                    ce_third_n,
    input  logic                    strobe_proc_n,
    input  logic                    strobe_ctrl_n,
    input  logic                    advance_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    byte_wr_n,
    input  logic                    all_wr_n,
    input  logic                    interleave,
    input  logic                    oe_n,
    input  logic                    sleep,
    input  logic [LANES*LANE_W-1:0] dq_i,
    output logic [LANES*LANE_W-1:0] dq_o,
    output logic                    dq_oe
);
    import fts_sram_pkg::*;

    acc_state_e        state;
    logic              start_proc, start_ctrl, selected, wr_req;
    logic              load, step, bus_drive, write_now;
    logic [LANES-1:0]  lane_mask, wr_lanes;
    logic [ADDR_W-1:0] access_addr, cur_addr;

    assign start_proc = !strobe_proc_n && !ce_first_n;
    assign start_ctrl = !strobe_ctrl_n;
    assign selected   = !ce_first_n && ce_second && !ce_third_n;

    always_comb begin
        if (!all_wr_n)      lane_mask = '1;
        else if (!byte_wr_n) lane_mask = ~lane_wr_n;
        else                lane_mask = '0;
    end
    assign wr_req = |lane_mask;

    assign load = !sleep && (start_proc || start_ctrl);
    assign step = !sleep && !load && !advance_n && (state != S_IDLE);

    fts_access_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep      (sleep),
        .start_proc (start_proc),
        .start_ctrl (start_ctrl),
        .selected   (selected),
        .wr_req     (wr_req),
        .oe_n       (oe_n),
        .state      (state),
        .bus_drive  (bus_drive),
        .write_now  (write_now)
    );

    fts_burst_ctr #(.ADDR_W(ADDR_W)) u_burst (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .step        (step),
        .interleave  (interleave),
        .start_addr  (addr),
        .access_addr (access_addr),
        .cur_addr    (cur_addr)
    );

    assign wr_lanes = write_now ? lane_mask : '0;

    fts_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .wr_addr (access_addr),
        .wr_en   (wr_lanes),
        .wr_data (dq_i),
        .rd_addr (cur_addr),
        .rd_data (dq_o)
    );

    assign dq_oe = bus_drive;

    assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!oe_n && !sleep))
        else $error("bus driven with output enable off or asleep");

    assert_write_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WRITE) |-> !dq_oe)
        else $error("bus driven during a write");

    assert_sleep_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (wr_lanes == '0))
        else $error("array written while asleep");

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !dq_oe)
        else $error("bus driven right after reset");

endmodule

// File: tb/fts_sram_bench.sv
`timescale 1ns/1ps
module fts_sram_bench;
    localparam int AW = 8;
    localparam int DW = 18;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic [AW-1:0] addr;
    logic          ce_a_n, ce_b, ce_c_n, sp_n, sc_n, adv_n, bwe_n, gw_n, mode, oe_n, sleep;
    logic [1:0]    lane_n;
    logic [DW-1:0] din, dout;
    logic          doe;

    fts_sram #(.ADDR_W(AW)) u_fts_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .ce_first_n(ce_a_n), .ce_second(ce_b), .ce_third_n(ce_c_n),
        .strobe_proc_n(sp_n), .strobe_ctrl_n(sc_n), .advance_n(adv_n),
        .lane_wr_n(lane_n), .byte_wr_n(bwe_n), .all_wr_n(gw_n),
        .interleave(mode), .oe_n(oe_n), .sleep(sleep),
        .dq_i(din), .dq_o(dout), .dq_oe(doe)
    );

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] ref_mem [1<<AW];

    bit            exp_oe_q [$];
    logic [DW-1:0] exp_d_q  [$];
    string         exp_r_q  [$];

    task automatic check(input string req, input bit ok, input logic act_oe,
                         input logic [DW-1:0] act_d, input bit exp_oe, input logic [DW-1:0] exp_d);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual oe=%b data=%h expected oe=%b data=%h",
                     req, act_oe, act_d, exp_oe, exp_d);
        end
    endtask

    // Monitor: compares one expected item per clock, away from the edge.
    always @(negedge clk) begin
        while (exp_oe_q.size() > 0) begin
            bit            eo;
            logic [DW-1:0] ed;
            string         rq;
            eo = exp_oe_q.pop_front();
            ed = exp_d_q.pop_front();
            rq = exp_r_q.pop_front();
            if (eo) check(rq, (doe === 1'b1) && (dout === ed), doe, dout, eo, ed);
            else    check(rq, doe === 1'b0, doe, dout, eo, ed);
        end
    end

    task automatic idle_inputs();
        sp_n = 1; sc_n = 1; adv_n = 1; lane_n = 2'b11; bwe_n = 1; gw_n = 1;
        ce_a_n = 0; ce_b = 1; ce_c_n = 0; din = '0;
    endtask

    // Driver: one clock with the inputs already set; pushes the expected result.
    task automatic step_cycle(input bit eo, input logic [DW-1:0] ed, input string req);
        @(posedge clk);
        exp_oe_q.push_back(eo); exp_d_q.push_back(ed); exp_r_q.push_back(req);
        @(negedge clk); #1;
        idle_inputs();
    endtask

    task automatic wr_ctrl(input logic [AW-1:0] a, input logic [DW-1:0] d);
        addr = a; sc_n = 0; gw_n = 0; din = d;
        step_cycle(1'b0, '0, "R4/R9 write cycle undriven");
        ref_mem[a] = d;
    endtask

    task automatic rd_proc(input logic [AW-1:0] a, input string req);
        addr = a; sp_n = 0;
        step_cycle(1'b1, ref_mem[a], req);
    endtask

    function automatic logic [AW-1:0] burst_at(input logic [AW-1:0] b, input int n, input bit il);
        logic [1:0] lo;
        lo = il ? (b[1:0] ^ 2'(n)) : (b[1:0] + 2'(n));
        return {b[AW-1:2], lo};
    endfunction

    initial begin
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] tmp;
        rst_n = 0; mode = 0; oe_n = 0; sleep = 0; addr = '0;
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset bus idle", doe === 1'b0, doe, dout, 1'b0, '0);
        #1 rst_n = 1;

        // R4: global write then R5/R3 processor read
        wr_ctrl(8'h10, 18'h2_5A3C);
        rd_proc(8'h10, "R5 flow-through read");

        // R4: lane 0 only (dq[8:0])
        addr = 8'h10; sc_n = 0; bwe_n = 0; lane_n = 2'b10; din = 18'h1_C0F1;
        tmp = ref_mem[8'h10];
        step_cycle(1'b0, '0, "R4 lane write undriven");
        ref_mem[8'h10] = {tmp[17:9], 9'h0F1};
        rd_proc(8'h10, "R4 lane0 written lane1 kept");

        // R4: lane enables without qualifier -> read, nothing written
        addr = 8'h10; sc_n = 0; bwe_n = 1; lane_n = 2'b00; din = 18'h3_3333;
        step_cycle(1'b1, ref_mem[8'h10], "R4 unqualified lanes read");
        rd_proc(8'h10, "R4 unqualified lanes wrote nothing");

        // R3: processor strobe ignores write controls; priority over controller
        addr = 8'h10; sp_n = 0; gw_n = 0; din = 18'h0_1111;
        step_cycle(1'b1, ref_mem[8'h10], "R3 proc start reads");
        addr = 8'h10; sp_n = 0; sc_n = 0; gw_n = 0; din = 18'h0_2222;
        step_cycle(1'b1, ref_mem[8'h10], "R3 proc wins over ctrl");
        rd_proc(8'h10, "R3 no write happened");

        // R6/R8: linear burst write from 0x22, then linear burst read
        mode = 0;
        addr = 8'h22; sc_n = 0; gw_n = 0; din = 18'h1_0000;
        step_cycle(1'b0, '0, "R8 burst write start");
        ref_mem[8'h22] = 18'h1_0000;
        for (int n = 1; n < 4; n++) begin
            adv_n = 0; gw_n = 0; din = 18'h1_0000 + 18'(n * 18'h111);
            step_cycle(1'b0, '0, "R8 burst write continue");
            ref_mem[burst_at(8'h22, n, 1'b0)] = 18'h1_0000 + 18'(n * 18'h111);
        end
        rd_proc(8'h22, "R6 linear first word");
        for (int n = 1; n < 4; n++) begin
            adv_n = 0;
            step_cycle(1'b1, ref_mem[burst_at(8'h22, n, 1'b0)], "R6 linear burst word");
        end

        // R7: interleaved burst read from 0x23
        mode = 1;
        rd_proc(8'h23, "R7 interleaved first word");
        for (int n = 1; n < 4; n++) begin
            adv_n = 0;
            step_cycle(1'b1, ref_mem[burst_at(8'h23, n, 1'b1)], "R7 interleaved burst word");
        end

        // R8: advance high holds, then steps
        rd_proc(8'h21, "R8 start");
        step_cycle(1'b1, ref_mem[8'h21], "R8 hold with advance high");
        adv_n = 0;
        step_cycle(1'b1, ref_mem[8'h20], "R8 step after hold");

        // R2: processor strobe ignored when first enable high
        ce_a_n = 1; sp_n = 0; addr = 8'h10;
        step_cycle(1'b1, ref_mem[8'h20], "R2 proc strobe ignored");

        // R2: deselected controller write, then continue, then deselected proc
        addr = 8'h10; sc_n = 0; ce_b = 0; gw_n = 0; din = 18'h2_EEEE;
        step_cycle(1'b0, '0, "R2 deselect undriven");
        adv_n = 0; gw_n = 0; din = 18'h2_EEEE;
        step_cycle(1'b0, '0, "R2 continue after deselect");
        addr = 8'h10; sp_n = 0; ce_c_n = 1;
        step_cycle(1'b0, '0, "R2 third enable deselects");
        rd_proc(8'h10, "R2 deselected write left data");

        // R9: asynchronous output enable
        rd_proc(8'h22, "R9 read before oe toggle");
        oe_n = 1; #1;
        check("R9 oe high releases bus", doe === 1'b0, doe, dout, 1'b0, '0);
        oe_n = 0; #1;
        check("R9 oe low drives again", (doe === 1'b1) && (dout === ref_mem[8'h22]),
              doe, dout, 1'b1, ref_mem[8'h22]);

        // R10: sleep
        rd_proc(8'h10, "R10 read before sleep");
        sleep = 1; #1;
        check("R10 sleep releases bus", doe === 1'b0, doe, dout, 1'b0, '0);
        addr = 8'h10; sc_n = 0; gw_n = 0; din = 18'h3_0F0F;
        step_cycle(1'b0, '0, "R10 write ignored asleep");
        adv_n = 0; sp_n = 0; addr = 8'h22;
        step_cycle(1'b0, '0, "R10 strobe ignored asleep");
        sleep = 0; #1;
        check("R10 idle after wake", doe === 1'b0, doe, dout, 1'b0, '0);
        step_cycle(1'b0, '0, "R10 stays idle after wake");
        rd_proc(8'h10, "R10 contents kept");

        repeat (2) @(posedge clk);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule